// File: doc/BRIEF.md
# Periodic Countdown Timer

A single-channel timer peripheral that sits on a plain 32-bit register bus (byte address, write strobe, write data, combinational read data). A power-of-two prescaler turns the input clock into ticks. A down-counter, started from a period value, decrements once per tick and raises a sticky flag when it reaches zero. The flag drives a level interrupt line.

Software writes the period, then sets the run bit in the control word. In one-shot mode the counter parks at zero after it expires. In auto-reload mode it picks up the period again and keeps running. The flag is cleared by writing a one to it. The control word reads back exactly as written, so single bits can be changed by read-modify-write.

Top module: `tick_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low. Any byte offset other than 0x00, 0x10 and 0x18 reads zero.
- R2: The control word at offset 0x18 reads back all 32 bits exactly as written. The period register at offset 0x10 reads back its stored value.
- R3: Bit 0 of the status word at offset 0x00 is the expiry flag. Writing 1 to it clears the flag, writing 0 leaves it unchanged, and `irq` equals the flag.
- R4: Control bits [3:0] hold a code c that sets the tick length to 2^(c+1) clocks. With period L, the flag rises exactly L*2^(c+1) clocks after the write that sets the run bit (bit 7). Code 14 gives 32768 clocks per tick.
- R5: With the mode bit (bit 4) clear, the counter stays at zero after it expires. The flag stays set until it is cleared, and it does not set again on its own.
- R6: With the mode bit set, the counter reloads the period when it expires and raises the flag again every L*2^(c+1) clocks.
- R7: Clearing the run bit freezes the count and leaves the other control bits unchanged.
- R8: When the run bit goes from 0 to 1, the counter restarts from the period value and the tick divider restarts from zero.
- R9: Writing the period while the timer runs restarts the countdown from the new value. Writing it while the timer is stopped only stores the value.
- R10: A period of zero never raises the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, high while the expiry flag is set |

## Verification
The bench measures each expiry to the exact clock, one cycle before and on the cycle of the expiry. A divider that is off by one, or a counter that fires on reaching one instead of on reaching zero, therefore shows up as a flag that is early or late. A period write in the middle of a countdown is checked against the moment the old period would have expired, so a design that ignores the restart is caught. The bench also re-enables the timer after it was stopped: a design that keeps the stale prescaler phase or the old count fires early. A write of zero to the status word must leave a set flag standing, and a one-shot timer left alone after its flag is cleared must stay silent, so a design that keeps reloading is caught.

// File: rtl/tick_timer_pkg.sv
`timescale 1ns/1ps
package tick_timer_pkg;
   typedef enum logic [1:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_LOAD,
      SEL_CTRL
   } reg_sel_e;

   localparam int unsigned CTRL_RUN_BIT  = 7;
   localparam int unsigned CTRL_AUTO_BIT = 4;
   localparam int unsigned STAT_FLAG_BIT = 0;
endpackage

// File: rtl/tick_timer_regs.sv
`timescale 1ns/1ps
module tick_timer_regs
   import tick_timer_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned STAT_OFS = 'h00,
   parameter int unsigned LOAD_OFS = 'h10,
   parameter int unsigned CTRL_OFS = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              expire_i,
   output logic              run_o,
   output logic              auto_o,
   output logic [CODE_W-1:0] code_o,
   output logic [DATA_W-1:0] load_o,
   output logic              restart_o,
   output logic [DATA_W-1:0] restart_val_o,
   output logic              flag_o
);
   reg_sel_e          sel;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] load_q;
   logic              flag_q;
   logic              wr_stat, wr_load, wr_ctrl;

   always_comb begin
      if (bus_addr == ADDR_W'(STAT_OFS))      sel = SEL_STAT;
      else if (bus_addr == ADDR_W'(LOAD_OFS)) sel = SEL_LOAD;
      else if (bus_addr == ADDR_W'(CTRL_OFS)) sel = SEL_CTRL;
      else                                    sel = SEL_NONE;
   end

   assign wr_stat = bus_we && (sel == SEL_STAT);
   assign wr_load = bus_we && (sel == SEL_LOAD);
   assign wr_ctrl = bus_we && (sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         load_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= bus_wdata;
         if (wr_load) load_q <= bus_wdata;
      end
   end

   // an expiry in the same cycle as a clearing write keeps the flag set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= 1'b0;
      else if (expire_i)
         flag_q <= 1'b1;
      else if (wr_stat && bus_wdata[STAT_FLAG_BIT])
         flag_q <= 1'b0;
   end

   // restart on a rising run bit, or on a period write while running
   always_comb begin
      restart_o     = 1'b0;
      restart_val_o = load_q;
      if (wr_ctrl && bus_wdata[CTRL_RUN_BIT] && !ctrl_q[CTRL_RUN_BIT]) begin
         restart_o     = 1'b1;
         restart_val_o = load_q;
      end else if (wr_load && ctrl_q[CTRL_RUN_BIT]) begin
         restart_o     = 1'b1;
         restart_val_o = bus_wdata;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_STAT: bus_rdata = DATA_W'(flag_q) << STAT_FLAG_BIT;
         SEL_LOAD: bus_rdata = load_q;
         SEL_CTRL: bus_rdata = ctrl_q;
         default:  bus_rdata = '0;
      endcase
   end

   assign run_o  = ctrl_q[CTRL_RUN_BIT];
   assign auto_o = ctrl_q[CTRL_AUTO_BIT];
   assign code_o = ctrl_q[CODE_W-1:0];
   assign load_o = load_q;
   assign flag_o = flag_q;
endmodule

// File: rtl/tick_timer_prescale.sv
`timescale 1ns/1ps
module tick_timer_prescale #(
   parameter int unsigned CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              clear_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              tick_o,
   output logic [(1<<CODE_W)-1:0] pre_o
);
   localparam int unsigned NCODES = 1 << CODE_W;
   localparam int unsigned PRE_W  = NCODES;

   logic [PRE_W-1:0]  pre_q;
   logic [NCODES-1:0] hit;
   logic              wrap;

   // code k ends a tick when the phase counter reaches 2^(k+1)-1
   for (genvar k = 0; k < NCODES; k++) begin : g_term
      localparam logic [PRE_W-1:0] TERM = {PRE_W{1'b1}} >> (PRE_W - 1 - k);
      assign hit[k] = (pre_q == TERM);
   end

   assign wrap   = hit[code_i];
   assign tick_o = run_i && !clear_i && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (clear_i)
         pre_q <= '0;
      else if (run_i)
         pre_q <= wrap ? '0 : pre_q + PRE_W'(1);
   end

   assign pre_o = pre_q;
endmodule

// File: rtl/tick_timer_count.sv
`timescale 1ns/1ps
module tick_timer_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] restart_val_i,
   input  logic             tick_i,
   input  logic             auto_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign expire_o = tick_i && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart_i)
         cnt_q <= restart_val_i;
      else if (tick_i && cnt_q != '0) begin
         if (cnt_q == ONE)
            cnt_q <= auto_i ? reload_i : '0;
         else
            cnt_q <= cnt_q - ONE;
      end
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
module tick_timer #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned CODE_W   = 4,
   parameter int unsigned STAT_OFS = 'h00,
   parameter int unsigned LOAD_OFS = 'h10,
   parameter int unsigned CTRL_OFS = 'h18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int unsigned PRE_W = 1 << CODE_W;

   if (ADDR_W < 5) begin : g_bad_addr
      $error("tick_timer: ADDR_W too small for the register offsets");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("tick_timer: DATA_W must hold the control bits");
   end
   if (CODE_W < 1 || CODE_W > 5) begin : g_bad_code
      $error("tick_timer: CODE_W out of range");
   end
   if (STAT_OFS == LOAD_OFS || STAT_OFS == CTRL_OFS || LOAD_OFS == CTRL_OFS) begin : g_bad_map
      $error("tick_timer: register offsets overlap");
   end

   logic              run, auto_mode, restart, tick, expire, flag;
   logic [CODE_W-1:0] code;
   logic [DATA_W-1:0] load_val, restart_val, cnt;
   logic [PRE_W-1:0]  pre;

   tick_timer_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
      .STAT_OFS(STAT_OFS), .LOAD_OFS(LOAD_OFS), .CTRL_OFS(CTRL_OFS)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .expire_i(expire),
      .run_o(run), .auto_o(auto_mode), .code_o(code), .load_o(load_val),
      .restart_o(restart), .restart_val_o(restart_val), .flag_o(flag)
   );

   tick_timer_prescale #(.CODE_W(CODE_W)) pre_i (
      .clk(clk), .rst_n(rst_n),
      .run_i(run), .clear_i(restart), .code_i(code),
      .tick_o(tick), .pre_o(pre)
   );

   tick_timer_count #(.CNT_W(DATA_W)) cnt_i (
      .clk(clk), .rst_n(rst_n),
      .restart_i(restart), .restart_val_i(restart_val),
      .tick_i(tick), .auto_i(auto_mode), .reload_i(load_val),
      .cnt_o(cnt), .expire_o(expire)
   );

   assign irq = flag;
endmodule

// File: rtl/tick_timer_chk.sv
`timescale 1ns/1ps
module tick_timer_chk #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned CNT_W    = 32,
   parameter int unsigned PRE_W    = 16,
   parameter int unsigned STAT_OFS = 'h00
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              clr_bit,
   input logic              irq,
   input logic              expire,
   input logic              restart,
   input logic [CNT_W-1:0]  restart_val,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  load_val,
   input logic              auto_mode,
   input logic              run,
   input logic [PRE_W-1:0]  pre
);
   logic clr_wr;
   assign clr_wr = bus_we && (bus_addr == ADDR_W'(STAT_OFS)) && clr_bit;

   assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(expire));

   assert_irq_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr && !expire |=> !irq);

   assert_irq_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clr_wr |=> irq);

   assert_restart_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == $past(restart_val)) && (pre == '0));

   assert_auto_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      expire && auto_mode |=> cnt == $past(load_val));

   assert_oneshot_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
      expire && !auto_mode |=> cnt == '0);

   assert_stopped_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !restart |=> $stable(cnt));

   assert_zero_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt == '0 |-> !expire);
endmodule

bind tick_timer tick_timer_chk #(
   .ADDR_W(ADDR_W), .CNT_W(DATA_W), .PRE_W(1 << CODE_W), .STAT_OFS(STAT_OFS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
   .clr_bit(bus_wdata[0]), .irq(irq), .expire(expire), .restart(restart),
   .restart_val(restart_val), .cnt(cnt), .load_val(load_val),
   .auto_mode(auto_mode), .run(run), .pre(pre)
);

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb_top;
   localparam int AW = 8;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq;

   always #10 clk = ~clk;

   tick_timer dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
      .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
   );

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int unsigned due;
      bit          is_rd;
      logic [31:0] exp;
      string       tag;
   } item_t;

   item_t sb[$];
   int    n_chk = 0;
   int    n_err = 0;
   bit    done  = 1'b0;

   // monitor: compare every expected item on its due cycle
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            n_chk++;
            if (it.due < cyc) begin
               n_err++;
               $display("FAIL %s: sampled at cycle %0d, expected at cycle %0d", it.tag, cyc, it.due);
            end else if (it.is_rd) begin
               if (rdata !== it.exp) begin
                  n_err++;
                  $display("FAIL %s: actual=%h expected=%h", it.tag, rdata, it.exp);
               end
            end else if (irq !== it.exp[0]) begin
               n_err++;
               $display("FAIL %s: actual irq=%b expected irq=%b", it.tag, irq, it.exp[0]);
            end
         end
      end
   end

   task automatic push(input int unsigned due, input bit is_rd, input logic [31:0] exp, input string tag);
      item_t it;
      int    pos;
      it.due = due; it.is_rd = is_rd; it.exp = exp; it.tag = tag;
      pos = sb.size();
      for (int i = 0; i < sb.size(); i++) begin
         if (sb[i].due > due) begin pos = i; break; end
      end
      sb.insert(pos, it);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
      addr = a;
      push(cyc, 1'b1, e, tag);
      @(negedge clk);
   endtask

   task automatic expect_irq(input int unsigned due, input bit v, input string tag);
      push(due, 1'b0, {31'd0, v}, tag);
   endtask

   task automatic wait_until(input int unsigned t);
      while (cyc < t) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned c0;
      int unsigned c1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state and unmapped offsets
      expect_irq(cyc, 1'b0, "R1 irq after reset");
      expect_rd(8'h00, 32'h0, "R1 status after reset");
      expect_rd(8'h10, 32'h0, "R1 period after reset");
      expect_rd(8'h18, 32'h0, "R1 control after reset");
      expect_rd(8'h04, 32'h0, "R1 unmapped 0x04");
      expect_rd(8'h14, 32'h0, "R1 unmapped 0x14");

      // R2 read-back, run bit clear
      wr(8'h18, 32'hA5A5_1234);
      expect_rd(8'h18, 32'hA5A5_1234, "R2 control read-back");
      wr(8'h10, 32'hDEAD_BEEF);
      expect_rd(8'h10, 32'hDEAD_BEEF, "R2 period read-back");
      wr(8'h18, 32'h0);

      // R9 period write while stopped does not start anything
      wr(8'h10, 32'd5);
      c0 = cyc;
      expect_irq(c0 + 20, 1'b0, "R9 stopped period write");
      wait_until(c0 + 20);

      // R4 one-shot, code 0: 5 ticks of 2 clocks
      wr(8'h18, 32'h80);
      c0 = cyc;
      expect_irq(c0 + 9, 1'b0, "R4 one-shot code0 before expiry");
      expect_irq(c0 + 10, 1'b1, "R4 one-shot code0 at expiry");
      wait_until(c0 + 10);
      c1 = cyc;
      expect_irq(c1 + 40, 1'b1, "R5 flag held after one-shot expiry");
      wait_until(c1 + 40);
      wr(8'h00, 32'h1);
      expect_irq(cyc, 1'b0, "R3 write one clears flag");
      c1 = cyc;
      expect_irq(c1 + 30, 1'b0, "R5 no second one-shot expiry");
      wait_until(c1 + 30);
      wr(8'h18, 32'h0);

      // R6 auto-reload, code 1: 3 ticks of 4 clocks
      wr(8'h10, 32'd3);
      wr(8'h18, 32'h91);
      c0 = cyc;
      expect_irq(c0 + 11, 1'b0, "R6 first period before expiry");
      expect_irq(c0 + 12, 1'b1, "R6 first period expiry");
      wait_until(c0 + 12);
      wr(8'h00, 32'h0);
      expect_irq(cyc, 1'b1, "R3 write zero keeps flag");
      expect_rd(8'h00, 32'h1, "R3 status reads flag");
      wr(8'h00, 32'h1);
      expect_irq(cyc, 1'b0, "R3 clear in auto mode");
      expect_irq(c0 + 23, 1'b0, "R6 second period before expiry");
      expect_irq(c0 + 24, 1'b1, "R6 second period expiry");
      wait_until(c0 + 24);
      wr(8'h00, 32'h1);
      expect_irq(c0 + 35, 1'b0, "R6 third period before expiry");
      expect_irq(c0 + 36, 1'b1, "R6 third period expiry");
      wait_until(c0 + 36);
      wr(8'h00, 32'h1);
      expect_rd(8'h18, 32'h91, "R2 control read-back while running");

      // R7 stop keeps the other bits and freezes the count
      wr(8'h18, 32'h11);
      expect_rd(8'h18, 32'h11, "R7 other bits kept");
      c1 = cyc;
      expect_irq(c1 + 60, 1'b0, "R7 stopped timer silent");
      wait_until(c1 + 60);

      // R8 re-enable restarts count and divider
      wr(8'h18, 32'h91);
      c0 = cyc;
      expect_irq(c0 + 11, 1'b0, "R8 restart before expiry");
      expect_irq(c0 + 12, 1'b1, "R8 restart expiry");
      wait_until(c0 + 12);
      wr(8'h00, 32'h1);

      // R9 period write while running restarts from the new value
      wait_until(c0 + 17);
      wr(8'h10, 32'd2);
      c1 = cyc;
      expect_irq(c1 + 7, 1'b0, "R9 running period write before expiry");
      expect_irq(c1 + 8, 1'b1, "R9 running period write expiry");
      wait_until(c1 + 8);
      wr(8'h00, 32'h1);
      wr(8'h18, 32'h0);

      // R10 zero period never expires
      wr(8'h10, 32'd0);
      wr(8'h18, 32'h90);
      c1 = cyc;
      expect_irq(c1 + 100, 1'b0, "R10 zero period silent");
      wait_until(c1 + 100);
      wr(8'h18, 32'h0);

      // R4 code 14: one tick of 32768 clocks
      wr(8'h10, 32'd1);
      wr(8'h18, 32'h8E);
      c0 = cyc;
      expect_irq(c0 + 32767, 1'b0, "R4 code14 before expiry");
      expect_irq(c0 + 32768, 1'b1, "R4 code14 expiry");
      wait_until(c0 + 32768);
      wr(8'h00, 32'h1);
      wr(8'h18, 32'h0);

      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule